// File: doc/BRIEF.md
# Endpoint FIFO with Packet Retry

This block is the byte store behind one endpoint of a USB device controller. Every endpoint gets its own instance, so the host may address endpoints in any order, the same one twice in a row included, and each buffer answers at once. The writer (the bus side for OUT traffic, the application for IN traffic) fills a working region that the reader cannot see until the writer commits it as a packet. The reader drains committed bytes through a speculative read position that it can either commit, which frees the space, or rewind to replay the packet.

Two pointer pairs carry this: a working and a committed write position, and a working and a committed read position. A bad OUT packet is dropped by a write discard. A lost IN packet is sent again after a read rewind. A mode input picks single buffering (one maximum-size packet in flight) or ping-pong double buffering (two). Each byte carries a ninth tag bit that marks the end of a frame. The transaction decoder sees the remaining space, the readable byte count and a flag that is high while any committed, unreleased byte is tagged. Writing into a full buffer or reading an empty one is harmless, but it sets a sticky error flag.

Top module: `efifo_retry`

## Requirements
- R1: After reset, bytes_avail is 0, eof_present is 0 and err is 0. bytes_free equals the capacity: MAX_PKT when dbl_mode is 0, or 2*MAX_PKT when dbl_mode is 1.
- R2: Written bytes become readable only after a wr_commit. bytes_avail counts committed bytes not yet read. rd_data shows the oldest such byte in the same cycle without waiting for a clock, rd_en consumes it, and order is first in, first out.
- R3: bytes_free equals the capacity minus the bytes held since the last rd_commit (committed, working and read-but-unreleased bytes all count). It is floored at 0. Read space returns only on rd_commit.
- R4: wr_discard returns the write position to the last commit and drops any wr_en in the same cycle. A wr_commit without wr_discard commits every byte written so far, including the one written in the same cycle.
- R5: rd_rewind returns the read position to the last rd_commit, so the same bytes are read again, and it ignores a rd_en in the same cycle. A rd_commit without rd_rewind releases every byte read so far, including the one read in the same cycle.
- R6: wr_eof is stored with its byte as a tag and shows on rd_eof when that byte is at the head. eof_present is 1 exactly when some byte that is committed but not yet released by rd_commit carries the tag.
- R7: A wr_en while the held bytes equal the capacity stores nothing, leaves every output except err unchanged, and sets err.
- R8: A rd_en with bytes_avail of 0 (and no rd_rewind) gives rd_data 0 and rd_eof 0, moves nothing and sets err. err stays 1 until reset.
- R9: The write side and the read side act in the same cycle without disturbing each other. Strobes that arrive together take effect as R4 and R5 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_mode | input | 1 | 1 selects double buffering (2*MAX_PKT capacity), 0 selects single |
| wr_en | input | 1 | Write one byte into the working region |
| wr_data | input | DATA_W | Byte to write |
| wr_eof | input | 1 | End-of-frame tag stored with the byte |
| wr_commit | input | 1 | Make all working bytes readable |
| wr_discard | input | 1 | Drop all uncommitted bytes |
| rd_en | input | 1 | Consume the head byte |
| rd_commit | input | 1 | Release all bytes read so far |
| rd_rewind | input | 1 | Return read position to last release |
| rd_data | output | DATA_W | Head byte, 0 when nothing is readable |
| rd_eof | output | 1 | Tag of the head byte, 0 when nothing is readable |
| bytes_avail | output | $clog2(DEPTH)+1 | Committed bytes not yet read |
| bytes_free | output | $clog2(DEPTH)+1 | Space left for writing |
| eof_present | output | 1 | A committed, unreleased byte is tagged |
| err | output | 1 | Sticky overflow or underflow flag |

## Verification
The bench targets the edges between the working and committed regions. These include a discard or commit in the same cycle as a write, a rewind in the same cycle as a read, and a read commit in the same cycle as a write discard. A design that misordered these would lose or replay one byte too many, which shows up at once in bytes_avail or rd_data. Filling to exactly the capacity in each mode catches an off-by-one full test, which would either drop the last legal byte or accept one byte too many. Tagged bytes that are read but not yet released must keep eof_present high. A design that cleared it on the read instead of on the release would report the end of frame too early for a packet that may still be replayed.

// File: rtl/efifo_pkg.sv
package efifo_pkg;
    localparam int unsigned EF_DEPTH_DEF   = 128;
    localparam int unsigned EF_DATA_W_DEF  = 8;
    localparam int unsigned EF_MAX_PKT_DEF = 64;

    // Width of a pointer or count: one wrap bit above the address.
    function automatic int unsigned ef_cnt_w(input int unsigned depth);
        return $clog2(depth) + 1;
    endfunction
endpackage

// File: rtl/efifo_store.sv
module efifo_store #(
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wtag,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rtag
);
    logic [DATA_W:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= {wtag, wdata};
    end

    assign {rtag, rdata} = mem_q[raddr];
endmodule

// File: rtl/efifo_wr_ctl.sv
module efifo_wr_ctl #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_eof,
    input  logic          wr_commit,
    input  logic          wr_discard,
    input  logic [CW-1:0] cap,
    input  logic [CW-1:0] rd_base,
    output logic [CW-1:0] work_ptr,
    output logic [CW-1:0] comm_ptr,
    output logic          push,
    output logic          overflow,
    output logic [CW-1:0] commit_tags,
    output logic [CW-1:0] free_cnt
);
    typedef struct packed {
        logic [CW-1:0] work;
        logic [CW-1:0] comm;
        logic [CW-1:0] tags;
    } wst_t;

    wst_t          s_q, s_d;
    logic [CW-1:0] used;
    logic          full;

    always_comb begin
        used        = s_q.work - rd_base;
        full        = used >= cap;
        push        = wr_en && !wr_discard && !full;
        overflow    = wr_en && !wr_discard && full;
        free_cnt    = full ? '0 : cap - used;
        commit_tags = '0;
        s_d         = s_q;
        if (wr_discard) begin
            s_d.work = s_q.comm;
            s_d.tags = '0;
        end else begin
            s_d.work = s_q.work + CW'(push);
            s_d.tags = s_q.tags + CW'(push && wr_eof);
            if (wr_commit) begin
                s_d.comm    = s_d.work;
                commit_tags = s_d.tags;
                s_d.tags    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign work_ptr = s_q.work;
    assign comm_ptr = s_q.comm;

    AST_DISCARD_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_discard |=> s_q.work == $past(s_q.comm)); // R4
    AST_COMMIT_ALIGNS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !wr_discard) |=> s_q.comm == s_q.work); // R4
    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !wr_commit) |=> s_q.work == $past(s_q.work)); // R7
endmodule

// File: rtl/efifo_rd_ctl.sv
module efifo_rd_ctl #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_commit,
    input  logic          rd_rewind,
    input  logic [CW-1:0] wr_limit,
    input  logic          head_tag,
    output logic [CW-1:0] work_ptr,
    output logic [CW-1:0] comm_ptr,
    output logic          pop,
    output logic          underflow,
    output logic [CW-1:0] release_tags,
    output logic [CW-1:0] avail
);
    typedef struct packed {
        logic [CW-1:0] work;
        logic [CW-1:0] comm;
        logic [CW-1:0] tags;
    } rst_t;

    rst_t s_q, s_d;
    logic empty;

    always_comb begin
        avail        = wr_limit - s_q.work;
        empty        = avail == '0;
        pop          = rd_en && !rd_rewind && !empty;
        underflow    = rd_en && !rd_rewind && empty;
        release_tags = '0;
        s_d          = s_q;
        if (rd_rewind) begin
            s_d.work = s_q.comm;
            s_d.tags = '0;
        end else begin
            s_d.work = s_q.work + CW'(pop);
            s_d.tags = s_q.tags + CW'(pop && head_tag);
            if (rd_commit) begin
                s_d.comm     = s_d.work;
                release_tags = s_d.tags;
                s_d.tags     = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign work_ptr = s_q.work;
    assign comm_ptr = s_q.comm;

    AST_REWIND_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rewind |=> s_q.work == $past(s_q.comm)); // R5
    AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> s_q.work == $past(s_q.work)); // R8
endmodule

// File: rtl/efifo_retry.sv
module efifo_retry
    import efifo_pkg::*;
#(
    parameter int unsigned DEPTH   = EF_DEPTH_DEF,
    parameter int unsigned DATA_W  = EF_DATA_W_DEF,
    parameter int unsigned MAX_PKT = EF_MAX_PKT_DEF,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned CW     = ef_cnt_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbl_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eof,
    input  logic              wr_commit,
    input  logic              wr_discard,
    input  logic              rd_en,
    input  logic              rd_commit,
    input  logic              rd_rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eof,
    output logic [CW-1:0]     bytes_avail,
    output logic [CW-1:0]     bytes_free,
    output logic              eof_present,
    output logic              err
);
    typedef struct packed {
        logic [CW-1:0] eof_cnt;
        logic          err;
    } top_t;

    top_t              t_q, t_d;
    logic [CW-1:0]     cap;
    logic [CW-1:0]     w_work, w_comm, r_work, r_comm;
    logic [CW-1:0]     commit_tags, release_tags;
    logic              push, pop, overflow, underflow;
    logic [DATA_W-1:0] head_data;
    logic              head_tag;

    assign cap = dbl_mode ? CW'(2 * MAX_PKT) : CW'(MAX_PKT);

    efifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (w_work[AW-1:0]),
        .wdata (wr_data),
        .wtag  (wr_eof),
        .raddr (r_work[AW-1:0]),
        .rdata (head_data),
        .rtag  (head_tag)
    );

    efifo_wr_ctl #(.CW(CW)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_eof      (wr_eof),
        .wr_commit   (wr_commit),
        .wr_discard  (wr_discard),
        .cap         (cap),
        .rd_base     (r_comm),
        .work_ptr    (w_work),
        .comm_ptr    (w_comm),
        .push        (push),
        .overflow    (overflow),
        .commit_tags (commit_tags),
        .free_cnt    (bytes_free)
    );

    efifo_rd_ctl #(.CW(CW)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .rd_commit    (rd_commit),
        .rd_rewind    (rd_rewind),
        .wr_limit     (w_comm),
        .head_tag     (head_tag),
        .work_ptr     (r_work),
        .comm_ptr     (r_comm),
        .pop          (pop),
        .underflow    (underflow),
        .release_tags (release_tags),
        .avail        (bytes_avail)
    );

    always_comb begin
        t_d         = t_q;
        t_d.eof_cnt = t_q.eof_cnt + commit_tags - release_tags;
        t_d.err     = t_q.err | overflow | underflow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rd_data     = (bytes_avail == '0) ? '0 : head_data;
    assign rd_eof      = (bytes_avail != '0) && head_tag;
    assign eof_present = t_q.eof_cnt != '0;
    assign err         = t_q.err;

    AST_AVAIL_LE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (w_comm - r_work) <= (w_work - r_comm)); // R2
    AST_EOF_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        eof_present |-> (w_comm != r_comm)); // R6
    AST_OVERFLOW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> err); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R8
    AST_POP_ONLY_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (w_comm != r_work)); // R2
endmodule

// File: tb/efifo_retry_bench.sv
`timescale 1ns/1ps
module efifo_retry_bench;
    localparam int DEPTH = 128;
    localparam int MP    = 64;
    localparam int CW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbl_mode = 1'b0;
    logic wr_en = 0, wr_eof = 0, wr_commit = 0, wr_discard = 0;
    logic [7:0] wr_data = '0;
    logic rd_en = 0, rd_commit = 0, rd_rewind = 0;
    logic [7:0] rd_data;
    logic rd_eof, eof_present, err;
    logic [CW-1:0] bytes_avail, bytes_free;

    always #2.5 clk = ~clk;

    efifo_retry #(.DEPTH(DEPTH), .DATA_W(8), .MAX_PKT(MP)) u_efifo_retry (
        .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode),
        .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
        .wr_commit(wr_commit), .wr_discard(wr_discard),
        .rd_en(rd_en), .rd_commit(rd_commit), .rd_rewind(rd_rewind),
        .rd_data(rd_data), .rd_eof(rd_eof), .bytes_avail(bytes_avail),
        .bytes_free(bytes_free), .eof_present(eof_present), .err(err)
    );

    // Reference model: queue holds every byte from the last read release onward.
    logic [8:0] mq[$];
    int  ncomm = 0;
    int  roff = 0;
    bit  merr = 0;
    int  n_run = 0, n_fail = 0;
    bit  finished = 0;
    string phase = "R1";

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d", req, phase, what, act, exp);
        end
    endtask

    task automatic tick();
        int cap, used, avail, e_data, e_tag, e_eofp;
        #1;
        cap   = dbl_mode ? 2 * MP : MP;
        used  = mq.size();
        avail = ncomm - roff;
        e_data = (avail > 0) ? int'(mq[roff][7:0]) : 0;
        e_tag  = (avail > 0) ? int'(mq[roff][8]) : 0;
        e_eofp = 0;
        for (int i = 0; i < ncomm; i++) if (mq[i][8]) e_eofp = 1;
        chk("R3", "bytes_free", int'(bytes_free), (used >= cap) ? 0 : cap - used);
        chk("R2", "bytes_avail", int'(bytes_avail), avail);
        chk("R2", "rd_data", int'(rd_data), e_data);
        chk("R6", "rd_eof", int'(rd_eof), e_tag);
        chk("R6", "eof_present", int'(eof_present), e_eofp);
        chk("R7/R8", "err", int'(err), int'(merr));
        @(posedge clk);
        // write side
        if (wr_discard) begin
            while (mq.size() > ncomm) void'(mq.pop_back());
        end else begin
            if (wr_en) begin
                if (used >= cap) merr = 1;
                else mq.push_back({wr_eof, wr_data});
            end
            if (wr_commit) ncomm = mq.size();
        end
        // read side
        if (rd_rewind) roff = 0;
        else begin
            if (rd_en) begin
                if (avail == 0) merr = 1;
                else roff++;
            end
            if (rd_commit) begin
                for (int i = 0; i < roff; i++) void'(mq.pop_front());
                ncomm -= roff;
                roff = 0;
            end
        end
        @(negedge clk);
        wr_en = 0; wr_eof = 0; wr_commit = 0; wr_discard = 0;
        rd_en = 0; rd_commit = 0; rd_rewind = 0;
    endtask

    task automatic do_reset(input bit dbl);
        rst_n = 0;
        dbl_mode = dbl;
        wr_en = 0; wr_eof = 0; wr_commit = 0; wr_discard = 0;
        rd_en = 0; rd_commit = 0; rd_rewind = 0;
        mq.delete(); ncomm = 0; roff = 0; merr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic put(input int v, input bit tag, input bit com);
        wr_en = 1; wr_data = 8'(v); wr_eof = tag; wr_commit = com;
        tick();
    endtask

    task automatic take(input bit com);
        rd_en = 1; rd_commit = com;
        tick();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state, single mode then double mode
        do_reset(0); phase = "R1"; tick();
        do_reset(1); tick();

        // R2: bytes hidden until commit, then read in order
        do_reset(0); phase = "R2";
        put(8'h11, 0, 0); put(8'h22, 0, 0); put(8'h33, 0, 0);
        tick();
        wr_commit = 1; tick();
        take(0); take(0); take(1);
        tick();

        // R3 and R7: fill single mode, overflow is dropped and flagged
        phase = "R3";
        for (int i = 0; i < MP; i++) put(i + 1, 0, i == MP - 1);
        phase = "R7";
        put(8'hEE, 0, 1);
        tick();
        take(0); take(1);
        phase = "R3";
        tick();

        // R3: double mode holds two packets
        do_reset(1); phase = "R3";
        for (int i = 0; i < 2 * MP; i++) put(i + 3, 0, (i % MP) == MP - 1);
        tick();
        for (int i = 0; i < MP; i++) take(i == MP - 1);
        tick();

        // R4: discard with a same-cycle write; commit with a same-cycle write
        do_reset(0); phase = "R4";
        for (int i = 0; i < 5; i++) put(8'h40 + i, 0, i == 4);
        for (int i = 0; i < 4; i++) put(8'h50 + i, 0, 0);
        wr_en = 1; wr_data = 8'h5F; wr_discard = 1; tick();
        put(8'h60, 0, 0); put(8'h61, 0, 1);
        for (int i = 0; i < 7; i++) take(i == 6);
        tick();

        // R5: replay after rewind, same-cycle read ignored, commit with read
        do_reset(0); phase = "R5";
        for (int i = 0; i < 6; i++) put(8'h70 + i, 0, i == 5);
        take(0); take(0); take(0);
        rd_rewind = 1; rd_en = 1; tick();
        for (int i = 0; i < 6; i++) take(i == 5);
        tick();

        // R6: tag follows its byte, flag cleared only by read release
        do_reset(0); phase = "R6";
        put(8'h80, 0, 0); put(8'h81, 0, 0); put(8'h82, 1, 0);
        tick();
        wr_commit = 1; tick();
        take(0); take(0); take(0);
        tick();
        rd_rewind = 1; tick();
        take(0); take(0); take(1);
        tick();

        // R8: read of empty gives zero, err sticks
        do_reset(0); phase = "R8";
        take(0);
        put(8'h90, 0, 1); take(1); tick();

        // R9: mixed concurrent traffic on both sides
        for (int m = 0; m < 2; m++) begin
            do_reset(bit'(m)); phase = "R9";
            for (int c = 0; c < 3000; c++) begin
                wr_en      = ($urandom % 2) == 0;
                wr_data    = 8'($urandom);
                wr_eof     = ($urandom % 10) == 0;
                wr_commit  = ($urandom % 8) == 0;
                wr_discard = ($urandom % 30) == 0;
                rd_en      = ($urandom % 2) == 0;
                rd_commit  = ($urandom % 8) == 0;
                rd_rewind  = ($urandom % 30) == 0;
                tick();
            end
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule